// File: doc/BRIEF.md
# Mantissa normalization left shifter

This block takes a 24-bit floating-point mantissa and shifts it left until its top bit is 1. The amount to shift is not known until the data itself arrives. A priority encoder counts the zeros above the first set bit. That count drives a five-level logarithmic shifter, and the whole operation finishes in one combinational pass. The datapath stays 24 bits wide throughout and is never widened to a power of two.

The block has three outputs: the normalized mantissa, the 5-bit shift count, and a flag that marks an all-zero input. Exponent logic downstream subtracts the shift count from the exponent. A parameter can place one register stage on the outputs so that a synchronous environment can sample them on a clock edge. That register is enabled by default.

Top module: `mant_norm`

## Requirements
- R1: For any nonzero input, bit 23 of the output mantissa is 1.
- R2: The shift count equals the number of zero bits above the highest set bit of the input, so it lies in the range 0 to 23.
- R3: The output mantissa equals the input shifted left by the shift count, with the vacated low positions filled with 0 and the bits shifted out at the top discarded.
- R4: An all-zero input sets the zero flag to 1 and gives an output mantissa of 0 and a shift count of 0.
- R5: The zero flag is 0 for every nonzero input.
- R6: With the output register enabled, each result appears on the outputs one clock edge after its input is sampled. While reset is held low, the outputs are mantissa 0, count 0 and zero flag 1.
- R7: The shift count never exceeds 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| mant_in | input | 24 | Mantissa to normalize |
| mant_out | output | 24 | Normalized mantissa |
| shamt_out | output | 5 | Left shift applied, equal to the leading-zero count |
| zero_out | output | 1 | High when the input mantissa is all zeros |

## Verification
Twenty-four one-hot inputs are applied, one for each bit position. This sweeps every shift count, so each shifter stage is tried both on and off in every combination the leading-one position can produce. Inputs with all bits set, and inputs with random bits below the leading one, show whether the stages move the trailing bits correctly and fill the bottom with zeros, which a one-hot pattern cannot show. The all-zero input and the reset state separate the zero-flag path from the smallest nonzero input, the value 1, which needs the largest shift of 23. Random values with a random number of leading zeros cover the rest of the space.

// File: rtl/norm_pkg.sv
package norm_pkg;
  localparam int MANT_W  = 24;
  localparam int SHAMT_W = $clog2(MANT_W);
endpackage

// File: rtl/norm_lzc.sv
module norm_lzc #(
  parameter int WIDTH = norm_pkg::MANT_W,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic [CNT_W-1:0] lead_zeros,
  output logic             all_zero
);
  // Priority encode: the highest set bit wins; no set bit yields 0.
  function automatic logic [CNT_W-1:0] count_lead(input logic [WIDTH-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (v[i]) c = CNT_W'(WIDTH - 1 - i);
    end
    return c;
  endfunction

  assign lead_zeros = count_lead(bits_in);
  assign all_zero   = ~|bits_in;
endmodule

// File: rtl/norm_shift_stage.sv
module norm_shift_stage #(
  parameter int WIDTH = norm_pkg::MANT_W,
  parameter int DIST  = 1
) (
  input  logic             en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  // One mux level: move up by DIST with zero fill, or pass straight through.
  assign d_out = en ? {d_in[WIDTH-1-DIST:0], {DIST{1'b0}}} : d_in;
endmodule

// File: rtl/norm_barrel.sv
module norm_barrel #(
  parameter int WIDTH = norm_pkg::MANT_W,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [CNT_W-1:0] amount,
  output logic [WIDTH-1:0] data_out
);
  logic [WIDTH-1:0] lvl [CNT_W+1];

  assign lvl[0] = data_in;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    norm_shift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
      .en   (amount[k]),
      .d_in (lvl[k]),
      .d_out(lvl[k+1])
    );
  end

  assign data_out = lvl[CNT_W];
endmodule

// File: rtl/mant_norm.sv
module mant_norm #(
  parameter int WIDTH   = norm_pkg::MANT_W,
  parameter int CNT_W   = $clog2(WIDTH),
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] mant_in,
  output logic [WIDTH-1:0] mant_out,
  output logic [CNT_W-1:0] shamt_out,
  output logic             zero_out
);
  localparam logic [CNT_W-1:0] MAX_SHIFT = CNT_W'(WIDTH - 1);

  // Combinational results, brought out as named wires for the checks.
  logic [CNT_W-1:0] comb_cnt;
  logic             comb_zero;
  logic [WIDTH-1:0] comb_mant;

  function automatic logic [WIDTH-1:0] below_mask(input logic [CNT_W-1:0] n);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (i < int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction

  norm_lzc #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_lzc (
    .bits_in   (mant_in),
    .lead_zeros(comb_cnt),
    .all_zero  (comb_zero)
  );

  norm_barrel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_barrel (
    .data_in (mant_in),
    .amount  (comb_cnt),
    .data_out(comb_mant)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mant_out  <= '0;
        shamt_out <= '0;
        zero_out  <= 1'b1;
      end else begin
        mant_out  <= comb_mant;
        shamt_out <= comb_cnt;
        zero_out  <= comb_zero;
      end
    end
  end else begin : g_comb
    assign mant_out  = comb_mant;
    assign shamt_out = comb_cnt;
    assign zero_out  = comb_zero;
  end

  // R1: a nonzero result is normalized
  p_msb_norm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_zero |-> comb_mant[WIDTH-1]);
  // R2: the bit the encoder points at is really set
  p_lead_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_zero |-> mant_in[WIDTH-1-int'(comb_cnt)]);
  // R3: the vacated low positions are zero
  p_low_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_mant & below_mask(comb_cnt)) == '0);
  // R4: a zero input passes through unshifted
  p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    comb_zero |-> (comb_mant == '0 && comb_cnt == '0));
  // R7: the count stays within the datapath
  p_shamt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shamt_out <= MAX_SHIFT);
endmodule

// File: tb/mant_norm_tb.sv
module mant_norm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mant_in = '0;
  logic [23:0] mant_out;
  logic [4:0]  shamt_out;
  logic        zero_out;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mant_norm u_dut (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in),
    .mant_out(mant_out), .shamt_out(shamt_out), .zero_out(zero_out)
  );

  // Reference: shift one place at a time until the top bit is set.
  function automatic logic [23:0] ref_mant(input logic [23:0] v);
    logic [23:0] m = v;
    if (v == 0) return 24'd0;
    while (!m[23]) m = m << 1;
    return m;
  endfunction

  function automatic int ref_count(input logic [23:0] v);
    int n = 0;
    logic [23:0] m = v;
    if (v == 0) return 0;
    while (!m[23]) begin m = m << 1; n++; end
    return n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] v);
    @(negedge clk);
    mant_in = v;
    @(posedge clk);
    @(negedge clk);
    // R6: result visible one edge after the input is sampled
    check(v == 0 ? "R4 mant" : "R3/R1 mant", int'(mant_out), int'(ref_mant(v)));
    check(v == 0 ? "R4 count" : "R2/R7 count", int'(shamt_out), ref_count(v));
    check(v == 0 ? "R4 zero" : "R5 zero", int'(zero_out), int'(v == 0));
    if (v != 0) check("R1 msb", int'(mant_out[23]), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6 reset state
    check("R6 reset mant", int'(mant_out), 0);
    check("R6 reset count", int'(shamt_out), 0);
    check("R6 reset zero", int'(zero_out), 1);
    rst_n = 1'b1;

    apply(24'h000000);
    apply(24'h000001);
    apply(24'h800000);
    apply(24'hFFFFFF);
    apply(24'h7FFFFF);
    apply(24'h000003);
    for (int b = 0; b < 24; b++) apply(24'd1 << b);
    for (int b = 0; b < 24; b++) apply(24'hFFFFFF >> b);
    apply(24'h000000);
    for (int n = 0; n < 400; n++) begin
      logic [23:0] r;
      r = 24'($urandom) >> ($urandom % 25);
      apply(r);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule